// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is a chain of boundary-scan cells that sits between a device core and its I/O pins. Every pin owns three cells: one watches the pin's input, one holds a test value for the pin's output data, and one holds a test value for the pin's output enable. Each cell pairs a capture/shift flop, clocked on the rising test clock, with an update latch, loaded on the falling test clock. The flops form one serial path from the test data input to the test data output.

An external test-port state machine and instruction decoder drive the block. They supply the capture, shift and update strobes and a select that says whether the external-test instruction is active. With the select low, the pins follow the core and the cells only observe, which serves sample and preload scans. With the select high, the update latches drive the pins. The latches may hold data loaded by any earlier scan, so interconnect between devices can be forced to known levels and read back.

A device-wide output-enable input can hold the core-driven pins tri-stated. The output-enable cells still record the core's own enable value while that input is low.

Top module: `bscan_chain`

## Requirements
- R1: An active-high synchronous `test_rst` clears every capture/shift flop on a rising `tck` edge. It clears every update latch on a falling `tck` edge, which leaves each latched output enable at 0 (disabled) and each latched output value at 0.
- R2: With `cap_en` high at a rising edge, each pin's input cell loads `pin_in`, its enable cell loads `core_oe` and its output cell loads `core_out`. Capture takes priority over shift.
- R3: With `shift_en` high and `cap_en` low at a rising edge, the chain moves one position toward `tdo`, and `tdi` enters at the far end. `tdo` always shows the flop nearest to it. For pin p, chain position 3p is the output cell, 3p+1 is the enable cell and 3p+2 is the input cell. Position 0 is nearest `tdo`.
- R4: A bit shifted in on `tdi` appears on `tdo` after exactly 3*N_PINS shift cycles, once every captured bit has left.
- R5: With `upd_en` high at a falling edge, every update latch copies its cell's capture/shift flop.
- R6: With `extest_sel` low, `pin_out` equals `core_out` and `pin_oe` equals `core_oe` ANDed with `pins_enable`.
- R7: With `extest_sel` high, `pin_out` and `pin_oe` come from the output and enable update latches in the same cycle. This includes values preloaded before the select rose. `pins_enable` has no effect while the select is high.
- R8: The enable cell captures `core_oe` even while `pins_enable` is low and the pins are tri-stated.
- R9: `core_in` follows `pin_in` in both modes.
- R10: The update latches, and therefore the pins in external-test mode, do not change during capture or shift cycles unless `upd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| test_rst | input | 1 | Synchronous active-high test reset |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| cap_en | input | 1 | Capture strobe, rising edge |
| shift_en | input | 1 | Shift strobe, rising edge |
| upd_en | input | 1 | Update strobe, falling edge |
| extest_sel | input | 1 | External-test instruction active |
| pins_enable | input | 1 | Device-wide output enable for the core path |
| core_out | input | N_PINS | Core output data per pin |
| core_oe | input | N_PINS | Core output enable per pin |
| core_in | output | N_PINS | Pin input values passed to the core |
| pin_in | input | N_PINS | Levels seen at the pins |
| pin_out | output | N_PINS | Data driven toward the pin drivers |
| pin_oe | output | N_PINS | Enable driven toward the pin drivers |

## Verification
Assertions inside each cell check on every edge that the reset empties the flop and that a capture loads the cell's observed value. They also check that a shift moves the neighbour's bit in, that an update copies the flop into the latch, and that the latch holds when no update strobe is present. The rest can only be shown by the bench's scenarios. These are the serial order and the 3*N_PINS delay from `tdi` to `tdo`, and the pins switching at once to preloaded data when the external-test select rises. They also include the external loopback readback through the input cells and the capture of the core's enable while the device-wide enable holds the pins off. A behavioural queue model is compared with the ports on every clock.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

    localparam int CELLS_PER_PIN = 3;

    // Position of a cell inside its pin's group; lower is nearer tdo.
    typedef enum logic [1:0] {
        CELL_OUT = 2'd0,
        CELL_OE  = 2'd1,
        CELL_IN  = 2'd2
    } cell_kind_e;

    // What is presented to one pin driver.
    typedef struct packed {
        logic data;
        logic en;
    } pin_drive_t;

    function automatic int cell_index(input int pin, input cell_kind_e kind);
        return pin * CELLS_PER_PIN + int'(kind);
    endfunction

endpackage

// File: rtl/bscan_cell.sv
`timescale 1ns/1ps
module bscan_cell (
    input  logic tck,
    input  logic rst,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    input  logic cap_val,
    input  logic scan_in,
    output logic scan_q,
    output logic upd_q
);

    // Capture/shift flop: rising edge, capture wins over shift.
    always_ff @(posedge tck) begin
        if (rst)           scan_q <= 1'b0;
        else if (cap_en)   scan_q <= cap_val;
        else if (shift_en) scan_q <= scan_in;
    end

    // Update latch: falling edge so the driven value never moves mid-shift.
    always_ff @(negedge tck) begin
        if (rst)         upd_q <= 1'b0;
        else if (upd_en) upd_q <= scan_q;
    end

    assert_reset_clears_R1: assert property (@(posedge tck)
        rst |=> (scan_q == 1'b0));

    assert_capture_loads_R2: assert property (@(posedge tck) disable iff (rst)
        cap_en |=> (scan_q == $past(cap_val)));

    assert_shift_moves_R3: assert property (@(posedge tck) disable iff (rst)
        (shift_en && !cap_en) |=> (scan_q == $past(scan_in)));

    assert_update_copies_R5: assert property (@(negedge tck) disable iff (rst)
        upd_en |=> (upd_q == $past(scan_q)));

    assert_latch_holds_R10: assert property (@(negedge tck) disable iff (rst)
        !upd_en |=> $stable(upd_q));

endmodule

// File: rtl/bscan_pin.sv
`timescale 1ns/1ps
module bscan_pin
    import bscan_pkg::*;
(
    input  logic tck,
    input  logic rst,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    input  logic extest_sel,
    input  logic pins_enable,
    input  logic core_out,
    input  logic core_oe,
    output logic core_in,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    input  logic scan_in,
    output logic scan_out
);

    logic in_q,  in_upd;
    logic oe_q,  oe_upd;
    logic out_q, out_upd;

    pin_drive_t core_drv, test_drv, sel_drv;

    // Order from the tdi side: input cell, enable cell, output cell.
    bscan_cell u_in_cell (
        .tck(tck), .rst(rst), .cap_en(cap_en), .shift_en(shift_en),
        .upd_en(upd_en), .cap_val(pin_in), .scan_in(scan_in),
        .scan_q(in_q), .upd_q(in_upd)
    );

    // Observes the core's enable, not the gated one (device-wide enable ignored).
    bscan_cell u_oe_cell (
        .tck(tck), .rst(rst), .cap_en(cap_en), .shift_en(shift_en),
        .upd_en(upd_en), .cap_val(core_oe), .scan_in(in_q),
        .scan_q(oe_q), .upd_q(oe_upd)
    );

    bscan_cell u_out_cell (
        .tck(tck), .rst(rst), .cap_en(cap_en), .shift_en(shift_en),
        .upd_en(upd_en), .cap_val(core_out), .scan_in(oe_q),
        .scan_q(out_q), .upd_q(out_upd)
    );

    always_comb begin
        core_drv.data = core_out;
        core_drv.en   = core_oe & pins_enable;
        test_drv.data = out_upd;
        test_drv.en   = oe_upd;
        sel_drv       = extest_sel ? test_drv : core_drv;
    end

    assign pin_out  = sel_drv.data;
    assign pin_oe   = sel_drv.en;
    assign core_in  = pin_in;
    assign scan_out = out_q;

    // The input cell's latch is never routed anywhere in this chain.
    logic unused_in_upd;
    assign unused_in_upd = in_upd;

endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              tck,
    input  logic              test_rst,
    input  logic              tdi,
    output logic              tdo,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              upd_en,
    input  logic              extest_sel,
    input  logic              pins_enable,
    input  logic [N_PINS-1:0] core_out,
    input  logic [N_PINS-1:0] core_oe,
    output logic [N_PINS-1:0] core_in,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);

    localparam int CHAIN_LEN = N_PINS * CELLS_PER_PIN;

    // link[p+1] feeds pin p; link[0] is the tdo end.
    logic [N_PINS:0] link;

    assign link[N_PINS] = tdi;
    assign tdo          = link[0];

    generate
        for (genvar p = 0; p < N_PINS; p++) begin : g_pin
            bscan_pin u_pin (
                .tck(tck), .rst(test_rst),
                .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
                .extest_sel(extest_sel), .pins_enable(pins_enable),
                .core_out(core_out[p]), .core_oe(core_oe[p]), .core_in(core_in[p]),
                .pin_in(pin_in[p]), .pin_out(pin_out[p]), .pin_oe(pin_oe[p]),
                .scan_in(link[p+1]), .scan_out(link[p])
            );
        end
    endgenerate

    initial begin
        assert (CHAIN_LEN == N_PINS * 3 && N_PINS > 0)
            else $error("chain length must be a positive multiple of three");
    end

endmodule

// File: tb/bscan_chain_tb.sv
`timescale 1ns/1ps
module bscan_chain_tb;

    localparam int NP = 4;
    localparam int L  = NP * 3;

    logic tck = 1'b0;
    always #2 tck = ~tck;   // 250 MHz

    logic test_rst, tdi, cap_en, shift_en, upd_en, extest_sel, pins_enable;
    logic [NP-1:0] core_out, core_oe, ext_in, pin_in;
    logic [NP-1:0] core_in, pin_out, pin_oe;
    logic tdo, loop, checking;

    int n_checks = 0;
    int n_fail   = 0;

    bscan_chain #(.N_PINS(NP)) u_dut (
        .tck(tck), .test_rst(test_rst), .tdi(tdi), .tdo(tdo),
        .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
        .extest_sel(extest_sel), .pins_enable(pins_enable),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // External loopback: pin p hears pin (p+1)%NP, pulled up when undriven.
    generate
        for (genvar p = 0; p < NP; p++) begin : g_lb
            assign pin_in[p] = loop ? (pin_oe[(p+1)%NP] ? pin_out[(p+1)%NP] : 1'b1)
                                    : ext_in[p];
        end
    endgenerate

    // ---------------- behavioural reference ----------------
    bit m_sr[$];
    bit m_upd[L];

    function automatic bit exp_out(int p);
        return extest_sel ? m_upd[3*p] : core_out[p];
    endfunction
    function automatic bit exp_oe(int p);
        return extest_sel ? m_upd[3*p+1] : (core_oe[p] & pins_enable);
    endfunction
    function automatic bit exp_in(int p);
        int s = (p + 1) % NP;
        if (!loop) return ext_in[p];
        return exp_oe(s) ? exp_out(s) : 1'b1;
    endfunction

    initial for (int i = 0; i < L; i++) m_sr.push_back(1'b0);

    always @(posedge tck) begin
        if (test_rst) begin
            for (int i = 0; i < L; i++) m_sr[i] = 1'b0;
        end else if (cap_en) begin
            for (int p = 0; p < NP; p++) begin
                m_sr[3*p]   = core_out[p];
                m_sr[3*p+1] = core_oe[p];
                m_sr[3*p+2] = exp_in(p);
            end
        end else if (shift_en) begin
            void'(m_sr.pop_front());
            m_sr.push_back(tdi);
        end
    end

    always @(negedge tck) begin
        if (test_rst) begin
            for (int i = 0; i < L; i++) m_upd[i] = 1'b0;
        end else if (upd_en) begin
            for (int i = 0; i < L; i++) m_upd[i] = m_sr[i];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, after the falling edge and before the next rise.
    always @(negedge tck) begin
        #1;
        if (checking && !test_rst) begin
            logic [NP-1:0] eo, ee, ei;
            for (int p = 0; p < NP; p++) begin
                eo[p] = exp_out(p);
                ee[p] = exp_oe(p);
                ei[p] = exp_in(p);
            end
            chk("R3 tdo", 32'(tdo), 32'(m_sr[0]));
            chk(extest_sel ? "R7 pin_out" : "R6 pin_out", 32'(pin_out), 32'(eo));
            chk(extest_sel ? "R7 pin_oe"  : "R6 pin_oe",  32'(pin_oe),  32'(ee));
            chk("R9 core_in", 32'(core_in), 32'(ei));
        end
    end

    // ---------------- stimulus helpers (entered at rise + 1 ns) ----------------
    task automatic capture();
        cap_en = 1'b1;
        @(posedge tck); #1;
        cap_en = 1'b0;
    endtask

    task automatic shift_bits(input logic [L-1:0] din, output logic [L-1:0] dout);
        for (int i = 0; i < L; i++) begin
            tdi      = din[i];
            shift_en = 1'b1;
            dout[i]  = tdo;
            @(posedge tck); #1;
        end
        shift_en = 1'b0;
        tdi      = 1'b0;
    endtask

    task automatic update();
        upd_en = 1'b1;
        @(posedge tck); #1;
        upd_en = 1'b0;
    endtask

    function automatic logic [L-1:0] pack(logic [NP-1:0] o, logic [NP-1:0] e, logic [NP-1:0] n);
        logic [L-1:0] v;
        for (int p = 0; p < NP; p++) begin
            v[3*p] = o[p]; v[3*p+1] = e[p]; v[3*p+2] = n[p];
        end
        return v;
    endfunction

    function automatic logic [NP-1:0] oe_bits(logic [L-1:0] v);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = v[3*p+1];
        return r;
    endfunction

    function automatic logic [NP-1:0] in_bits(logic [L-1:0] v);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = v[3*p+2];
        return r;
    endfunction

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [L-1:0] d, d2, pre, mark;
        logic [NP-1:0] p_out, p_oe, exp_lb;

        checking = 1'b0; loop = 1'b0;
        test_rst = 1'b1; tdi = 1'b0; cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0;
        extest_sel = 1'b0; pins_enable = 1'b1;
        core_out = '0; core_oe = '0; ext_in = '0;
        repeat (3) @(posedge tck);
        #1 test_rst = 1'b0;
        checking = 1'b1;

        // R1: latches cleared, seen through the external-test path
        extest_sel = 1'b1;
        #2;
        chk("R1 pin_oe after reset", 32'(pin_oe), 32'h0);
        chk("R1 pin_out after reset", 32'(pin_out), 32'h0);
        chk("R1 tdo after reset", 32'(tdo), 32'h0);
        @(posedge tck); #1;
        extest_sel = 1'b0;

        // R2/R3/R9: sample in normal mode
        core_out = 4'b1010; core_oe = 4'b0110; ext_in = 4'b0011;
        #2;
        chk("R9 core_in follows pin_in", 32'(core_in), 32'(ext_in));
        @(posedge tck); #1;
        capture();
        chk("R3 first tdo bit is pin0 output cell", 32'(tdo), 32'(core_out[0]));
        shift_bits('0, d);
        chk("R2 captured chain", 32'(d), 32'(pack(4'b1010, 4'b0110, 4'b0011)));

        // R8: enable cell sees core enable while pins are held off
        pins_enable = 1'b0; core_oe = 4'b1111; core_out = 4'b0101;
        #2;
        chk("R6 pins held off by device enable", 32'(pin_oe), 32'h0);
        @(posedge tck); #1;
        capture();
        shift_bits('0, d);
        chk("R8 captured enables", 32'(oe_bits(d)), 32'hF);

        // Preload, then switch to external test
        pins_enable = 1'b1;
        p_out = 4'b1001; p_oe = 4'b1011;
        pre = pack(p_out, p_oe, 4'b0000);
        shift_bits(pre, d);
        update();
        #2;
        chk("R6 core path after preload", 32'(pin_out), 32'(core_out));
        @(posedge tck); #1;
        pins_enable = 1'b0;
        extest_sel  = 1'b1;
        #0.5;
        chk("R7 preloaded out driven at once", 32'(pin_out), 32'(p_out));
        chk("R7 preloaded oe, device enable ignored", 32'(pin_oe), 32'(p_oe));
        @(posedge tck); #1;

        // Loopback capture and readback
        loop = 1'b1;
        for (int p = 0; p < NP; p++)
            exp_lb[p] = p_oe[(p+1)%NP] ? p_out[(p+1)%NP] : 1'b1;
        @(posedge tck); #1;
        capture();
        shift_bits('0, d);
        chk("R7 loopback read by input cells", 32'(in_bits(d)), 32'(exp_lb));
        chk("R10 pins unchanged after shifting", 32'(pin_out), 32'(p_out));
        chk("R10 enables unchanged after shifting", 32'(pin_oe), 32'(p_oe));

        // R5: update loads the zeros just shifted in
        update();
        #2;
        chk("R5 update copied zeros to enables", 32'(pin_oe), 32'h0);
        @(posedge tck); #1;
        loop = 1'b0;

        // R4: tdi to tdo delay equals chain length
        mark = 12'hA5C;
        capture();
        shift_bits(mark, d);
        shift_bits('0, d2);
        chk("R4 bits reappear after chain length", 32'(d2), 32'(mark));

        extest_sel = 1'b0;
        repeat (3) @(posedge tck);
        #1;
        checking = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule